// File: doc/BRIEF.md
# Fetch Redirect and Control-Hazard Unit

This block owns the program counter of a three-stage RV32I pipeline. The first stage fetches and decodes, the second executes and accesses memory, and the third writes back. Every cycle the block chooses the next instruction-memory address. It also decides whether the word now in decode is replaced by a bubble.

Unconditional direct jumps are resolved in decode. A dedicated adder adds the jump offset to the decode-stage PC, and the sum goes straight to the instruction memory, so such a jump costs no cycle. Conditional branches and register-indirect jumps are resolved one stage later. The instruction fetched behind either one is therefore always turned into a no-op. If a branch is not taken, the unit refetches the squashed word by presenting the incremented PC minus four, and the PC register is never clock-gated. A taken branch or an indirect jump loads the target that the execute stage supplies. An indirect target has its lowest bit forced to zero.

The surrounding core gives the unit the class of the decoded instruction, the direct-jump offset, the raw instruction word, the branch outcome and the target from execute. The core uses the unit's next address, its decode PC and its filtered instruction word.

Top module: `fetch_redirect_unit`

## Requirements
- R1: While `rst_n` is low, `imem_addr` equals `BOOT_ADDR`, `dec_kill` is 1 and `pc_hold` is 0. In the first cycle after release, `fetch_pc` equals `BOOT_ADDR`.
- R2: When decode holds a live instruction of class other (`dec_class` = 0) and nothing in execute redirects or holds, `imem_addr` equals `fetch_pc` + 4. `fetch_pc` in each cycle equals the `imem_addr` of the cycle before.
- R3: A live direct jump in decode (`dec_class` = 2) makes `imem_addr` equal `fetch_pc` plus the sign-extended `dec_jal_imm` in that same cycle, and it does not kill the following decode slot.
- R4: A live branch (`dec_class` = 1) or indirect jump (`dec_class` = 3) in decode makes `dec_kill` 1 in the next cycle. A killed slot shows `dec_insn` = 0x00000013.
- R5: In the cycle after a live branch, a taken outcome (`ex_br_taken` = 1) sets `imem_addr` to `ex_target`.
- R6: In the cycle after a live branch, a not-taken outcome sets `pc_hold` to 1 and `imem_addr` to `fetch_pc`, so the squashed word is fetched again.
- R7: In the cycle after a live indirect jump, `imem_addr` equals `ex_target` with bit 0 cleared, whatever `ex_br_taken` holds.
- R8: The class of a killed decode slot is ignored: it neither redirects as a direct jump nor kills the slot that follows.
- R9: When `dec_kill` is 0, `dec_insn` equals `dec_insn_raw`.
- R10: `pc_hold` is 1 only in the cycle after a live branch whose outcome is not taken. The next-address priority is reset, then a taken branch or indirect jump, then direct jump, then hold, then sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_class | input | 2 | Class of decode word: 0 other, 1 branch, 2 direct jump, 3 indirect jump |
| dec_jal_imm | input | JIMM_W | Signed direct-jump offset of the decode word |
| dec_insn_raw | input | 32 | Instruction word read from memory |
| ex_br_taken | input | 1 | Comparator outcome for the branch in execute |
| ex_target | input | XLEN | Branch or indirect-jump target computed in execute |
| imem_addr | output | XLEN | Next fetch address |
| fetch_pc | output | XLEN | PC of the word in decode |
| dec_kill | output | 1 | Decode slot replaced by a no-op |
| dec_insn | output | 32 | Instruction word after bubble insertion |
| pc_hold | output | 1 | Refetch of the current PC selected |

## Verification
The bench builds the unit with XLEN = 32, a 21-bit jump offset, the default boot address and the subtract-four hold variant. With these values, negative jump offsets wrap through the full 32-bit space, and odd indirect targets exercise the bit-0 clear. The hold path is checked through its extra subtractor rather than through a plain copy of the PC. Random class and outcome streams produce back-to-back branches, jumps sitting in squashed slots, and refetched branches, and each fetched PC is compared with a model of the required sequence.

// File: rtl/frx_pkg.sv
package frx_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER  = 2'd0,
      CLS_BRANCH = 2'd1,
      CLS_JAL    = 2'd2,
      CLS_JALR   = 2'd3
   } ctl_cls_e;

   typedef enum logic [2:0] {
      NXT_BOOT  = 3'd0,
      NXT_REDIR = 3'd1,
      NXT_JAL   = 3'd2,
      NXT_HOLD  = 3'd3,
      NXT_SEQ   = 3'd4
   } nxt_sel_e;

   localparam int          INSN_W   = 32;
   localparam logic [31:0] NOP_WORD = 32'h0000_0013;

endpackage

// File: rtl/frx_ex_track.sv
module frx_ex_track
   import frx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ctl_cls_e dec_cls,
   input  logic     dec_kill,
   output logic     ex_is_branch,
   output logic     ex_is_jalr
);

   ctl_cls_e ex_cls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_cls_q <= CLS_OTHER;
      end else begin
         ex_cls_q <= dec_kill ? CLS_OTHER : dec_cls;
      end
   end

   assign ex_is_branch = (ex_cls_q == CLS_BRANCH);
   assign ex_is_jalr   = (ex_cls_q == CLS_JALR);

endmodule

// File: rtl/frx_sel.sv
module frx_sel
   import frx_pkg::*;
(
   input  logic     rst_n,
   input  logic     ex_is_branch,
   input  logic     ex_is_jalr,
   input  logic     ex_taken,
   input  ctl_cls_e dec_cls,
   output nxt_sel_e sel,
   output logic     dec_kill,
   output logic     pc_hold
);

   logic redirect;
   logic hold;
   logic jal_live;

   assign redirect = ex_is_jalr | (ex_is_branch & ex_taken);
   assign hold     = ex_is_branch & ~ex_taken;
   assign dec_kill = ~rst_n | ex_is_branch | ex_is_jalr;
   assign jal_live = ~dec_kill & (dec_cls == CLS_JAL);

   always_comb begin
      if (!rst_n)        sel = NXT_BOOT;
      else if (redirect) sel = NXT_REDIR;
      else if (jal_live) sel = NXT_JAL;
      else if (hold)     sel = NXT_HOLD;
      else               sel = NXT_SEQ;
   end

   assign pc_hold = (sel == NXT_HOLD);

endmodule

// File: rtl/frx_pc_gen.sv
module frx_pc_gen
   import frx_pkg::*;
#(
   parameter int             XLEN        = 32,
   parameter int             JIMM_W      = 21,
   parameter logic [XLEN-1:0] BOOT_ADDR  = 32'h4000_0000,
   parameter bit             HOLD_BY_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  nxt_sel_e          sel,
   input  logic [JIMM_W-1:0] jal_imm,
   input  logic [XLEN-1:0]   ex_target,
   input  logic              ex_is_jalr,
   output logic [XLEN-1:0]   next_pc,
   output logic [XLEN-1:0]   pc_q
);

   localparam logic [XLEN-1:0] STEP  = XLEN'(4);
   localparam int              EXT_W = XLEN - JIMM_W;

   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] jal_tgt;
   logic [XLEN-1:0] redir_tgt;
   logic [XLEN-1:0] hold_pc;
   logic [XLEN-1:0] imm_ext;

   assign pc_plus4  = pc_q + STEP;
   assign imm_ext   = {{EXT_W{jal_imm[JIMM_W-1]}}, jal_imm};
   assign jal_tgt   = pc_q + imm_ext;
   assign redir_tgt = ex_is_jalr ? {ex_target[XLEN-1:1], 1'b0} : ex_target;

   generate
      if (HOLD_BY_SUB) begin : g_hold_sub
         assign hold_pc = pc_plus4 - STEP;
      end else begin : g_hold_copy
         assign hold_pc = pc_q;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         NXT_BOOT:  next_pc = BOOT_ADDR;
         NXT_REDIR: next_pc = redir_tgt;
         NXT_JAL:   next_pc = jal_tgt;
         NXT_HOLD:  next_pc = hold_pc;
         default:   next_pc = pc_plus4;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= BOOT_ADDR;
      end else begin
         pc_q <= next_pc;
      end
   end

endmodule

// File: rtl/frx_nop_inject.sv
module frx_nop_inject
   import frx_pkg::*;
(
   input  logic              dec_kill,
   input  logic [INSN_W-1:0] raw,
   output logic [INSN_W-1:0] insn
);

   assign insn = dec_kill ? NOP_WORD : raw;

endmodule

// File: rtl/fetch_redirect_unit.sv
module fetch_redirect_unit
   import frx_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              JIMM_W      = 21,
   parameter logic [XLEN-1:0] BOOT_ADDR   = 32'h4000_0000,
   parameter bit              HOLD_BY_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        dec_class,
   input  logic [JIMM_W-1:0] dec_jal_imm,
   input  logic [31:0]       dec_insn_raw,
   input  logic              ex_br_taken,
   input  logic [XLEN-1:0]   ex_target,
   output logic [XLEN-1:0]   imem_addr,
   output logic [XLEN-1:0]   fetch_pc,
   output logic              dec_kill,
   output logic [31:0]       dec_insn,
   output logic              pc_hold
);

   generate
      if (JIMM_W < 2 || XLEN <= JIMM_W) begin : g_bad_width
         $error("fetch_redirect_unit: JIMM_W must be >= 2 and below XLEN");
      end
      if (BOOT_ADDR[1:0] != 2'b00) begin : g_bad_boot
         $error("fetch_redirect_unit: BOOT_ADDR must be word aligned");
      end
   endgenerate

   ctl_cls_e dec_cls;
   nxt_sel_e sel;
   logic     ex_is_branch;
   logic     ex_is_jalr;

   assign dec_cls = ctl_cls_e'(dec_class);

   frx_ex_track u_ex_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec_cls      (dec_cls),
      .dec_kill     (dec_kill),
      .ex_is_branch (ex_is_branch),
      .ex_is_jalr   (ex_is_jalr)
   );

   frx_sel u_sel (
      .rst_n        (rst_n),
      .ex_is_branch (ex_is_branch),
      .ex_is_jalr   (ex_is_jalr),
      .ex_taken     (ex_br_taken),
      .dec_cls      (dec_cls),
      .sel          (sel),
      .dec_kill     (dec_kill),
      .pc_hold      (pc_hold)
   );

   frx_pc_gen #(
      .XLEN        (XLEN),
      .JIMM_W      (JIMM_W),
      .BOOT_ADDR   (BOOT_ADDR),
      .HOLD_BY_SUB (HOLD_BY_SUB)
   ) u_pc_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .jal_imm    (dec_jal_imm),
      .ex_target  (ex_target),
      .ex_is_jalr (ex_is_jalr),
      .next_pc    (imem_addr),
      .pc_q       (fetch_pc)
   );

   frx_nop_inject u_nop (
      .dec_kill (dec_kill),
      .raw      (dec_insn_raw),
      .insn     (dec_insn)
   );

endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk #(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] BOOT_ADDR = 32'h4000_0000
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      dec_class,
   input logic            dec_kill,
   input logic            pc_hold,
   input logic [XLEN-1:0] imem_addr,
   input logic [XLEN-1:0] fetch_pc,
   input logic [31:0]     dec_insn
);

   p_boot_addr_r1: assert property (@(posedge clk)
      !rst_n |-> (imem_addr == BOOT_ADDR && dec_kill && !pc_hold));

   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_class == 2'd0 && !dec_kill) |-> imem_addr == fetch_pc + XLEN'(4));

   p_fetch_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> fetch_pc == $past(imem_addr));

   p_bubble_after_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((dec_class == 2'd1 || dec_class == 2'd3) && !dec_kill) |=> dec_kill);

   p_nop_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_kill |-> dec_insn == 32'h0000_0013);

   p_refetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> imem_addr == fetch_pc);

   p_jalr_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_class == 2'd3 && !dec_kill) |=> imem_addr[0] == 1'b0);

   p_killed_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_kill |=> !dec_kill);

   p_hold_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> $past(dec_class == 2'd1 && !dec_kill));

endmodule

bind fetch_redirect_unit fetch_redirect_chk #(
   .XLEN      (XLEN),
   .BOOT_ADDR (BOOT_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dec_class (dec_class),
   .dec_kill  (dec_kill),
   .pc_hold   (pc_hold),
   .imem_addr (imem_addr),
   .fetch_pc  (fetch_pc),
   .dec_insn  (dec_insn)
);

// File: tb/test_fetch_redirect_unit.sv
module test_fetch_redirect_unit;

   localparam int          CLK_PERIOD = 10;
   localparam int          XLEN       = 32;
   localparam int          JIMM_W     = 21;
   localparam logic [31:0] BOOT       = 32'h4000_0000;
   localparam logic [31:0] NOP        = 32'h0000_0013;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        dec_class = 2'd0;
   logic [JIMM_W-1:0] dec_jal_imm = '0;
   logic [31:0]       dec_insn_raw = '0;
   logic              ex_br_taken = 1'b0;
   logic [XLEN-1:0]   ex_target = '0;
   logic [XLEN-1:0]   imem_addr;
   logic [XLEN-1:0]   fetch_pc;
   logic              dec_kill;
   logic [31:0]       dec_insn;
   logic              pc_hold;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [31:0] m_pc;
   logic [1:0]  m_ex;
   logic        m_tk;
   logic [31:0] m_tgt;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fetch_redirect_unit #(
      .XLEN        (XLEN),
      .JIMM_W      (JIMM_W),
      .BOOT_ADDR   (BOOT),
      .HOLD_BY_SUB (1'b1)
   ) i_fetch_redirect_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec_class    (dec_class),
      .dec_jal_imm  (dec_jal_imm),
      .dec_insn_raw (dec_insn_raw),
      .ex_br_taken  (ex_br_taken),
      .ex_target    (ex_target),
      .imem_addr    (imem_addr),
      .fetch_pc     (fetch_pc),
      .dec_kill     (dec_kill),
      .dec_insn     (dec_insn),
      .pc_hold      (pc_hold)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] sext_imm(input logic [JIMM_W-1:0] imm);
      return {{(XLEN-JIMM_W){imm[JIMM_W-1]}}, imm};
   endfunction

   function automatic logic [31:0] exp_next(input logic [1:0] cls, input logic [JIMM_W-1:0] imm);
      if (m_ex == 2'd3)              return {m_tgt[31:1], 1'b0};
      if (m_ex == 2'd1 && m_tk)      return m_tgt;
      if (m_ex == 2'd1)              return m_pc;
      if (cls == 2'd2)               return m_pc + sext_imm(imm);
      return m_pc + 32'd4;
   endfunction

   function automatic string next_tag(input logic [1:0] cls);
      if (m_ex == 2'd3)         return "R7";
      if (m_ex == 2'd1 && m_tk) return "R5";
      if (m_ex == 2'd1)         return "R6";
      if (cls == 2'd2)          return "R3";
      return "R2";
   endfunction

   // One decode cycle. tk/tgt describe the outcome this decode word will
   // present when it reaches execute in the following cycle.
   task automatic cycle(input logic [1:0] cls, input logic [JIMM_W-1:0] imm,
                        input logic [31:0] raw, input logic tk, input logic [31:0] tgt);
      logic [31:0] nx;
      logic        kill_e;
      logic        hold_e;
      dec_class    = cls;
      dec_jal_imm  = imm;
      dec_insn_raw = raw;
      ex_br_taken  = m_tk;
      ex_target    = m_tgt;
      #1;
      kill_e = (m_ex == 2'd1) || (m_ex == 2'd3);
      hold_e = (m_ex == 2'd1) && !m_tk;
      nx     = exp_next(cls, imm);
      chk("R2 fetch_pc", fetch_pc, m_pc);
      chk(next_tag(cls), imem_addr, nx);
      chk(kill_e ? "R4 kill" : "R8 kill", {31'd0, dec_kill}, {31'd0, kill_e});
      chk("R10 hold", {31'd0, pc_hold}, {31'd0, hold_e});
      chk(kill_e ? "R4 nop" : "R9 insn", dec_insn, kill_e ? NOP : raw);
      m_ex  = kill_e ? 2'd0 : ((cls == 2'd1 || cls == 2'd3) ? cls : 2'd0);
      m_tk  = tk;
      m_tgt = tgt;
      m_pc  = nx;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 addr", imem_addr, BOOT);
      chk("R1 kill", {31'd0, dec_kill}, 32'd1);
      chk("R1 hold", {31'd0, pc_hold}, 32'd0);
      rst_n = 1'b1;
      m_pc  = BOOT;
      m_ex  = 2'd0;
      m_tk  = 1'b0;
      m_tgt = '0;
      #1;
      chk("R1 first pc", fetch_pc, BOOT);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd2024);
      do_reset();

      // R2 sequential stream
      cycle(2'd0, '0, 32'h0010_0093, 1'b0, 32'h0);
      cycle(2'd0, '0, 32'h0020_0113, 1'b0, 32'h0);
      // R3 forward and backward direct jumps
      cycle(2'd2, 21'h000100, 32'h1000_006F, 1'b0, 32'h0);
      cycle(2'd2, 21'h1FFFF8, 32'hFF9F_F06F, 1'b0, 32'h0);
      // R5 taken branch, jump in squashed slot ignored (R8)
      cycle(2'd1, '0, 32'h0020_8463, 1'b1, 32'h4000_0800);
      cycle(2'd2, 21'h000400, 32'h4000_006F, 1'b0, 32'h0);
      cycle(2'd0, '0, 32'h0000_0033, 1'b0, 32'h0);
      // R6 not-taken branch, branch class in squashed slot ignored (R8)
      cycle(2'd1, '0, 32'h0020_9463, 1'b0, 32'h4000_0900);
      cycle(2'd1, '0, 32'h0031_0463, 1'b1, 32'h4000_0A00);
      // refetched word is itself a taken branch
      cycle(2'd1, '0, 32'h0031_0463, 1'b1, 32'h4000_0A00);
      cycle(2'd0, '0, 32'h0000_0033, 1'b0, 32'h0);
      // R7 indirect jump with odd target and taken flag low
      cycle(2'd3, '0, 32'h0000_80E7, 1'b0, 32'h4000_1235);
      cycle(2'd0, '0, 32'h0000_0033, 1'b1, 32'h0);
      cycle(2'd0, '0, 32'h0000_0033, 1'b0, 32'h0);
      // R1 reset in mid-stream
      cycle(2'd1, '0, 32'h0020_8463, 1'b1, 32'h4000_0800);
      do_reset();

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         logic [31:0] t;
         r = $urandom;
         t = $urandom;
         if (r[7:5] == 3'd0 && r[8]) begin
            cycle(r[1:0], 21'(r[30:10]) & 21'h1FFFFC, r, r[4], t);
            do_reset();
         end else begin
            cycle(r[1:0], 21'(r[30:10]) & 21'h1FFFFC, r, r[4],
                  r[1:0] == 2'd3 ? t : {t[31:2], 2'b00});
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule